// File: doc/BRIEF.md
# Display Read-Buffer Priority Controller with Transition Watermark

This block sits beside the read buffer of one display plane and marks every memory read that the plane issues as either urgent or relaxed. The buffer fill level arrives each cycle as a count of blocks. While the buffer is starved, reads are urgent. Once the fill climbs past an upper threshold, the transition watermark, reads become relaxed so that other memory clients are served better. Reads stay relaxed until the fill drops under the lower threshold, the level-0 watermark, and then the cycle starts again.

The upper threshold is computed inside the block from a configuration set that is captured on a load strobe. The set holds the level-0 watermark, the tiling mode, the Y-tile minimum as a fixed-point value, a tunable transition amount, an idle-priority enable, a pipe-active flag, an early-silicon correction flag and the buffer allocation. When the pipe is idle, when idle priority control is off, or when the threshold does not fit in the allocation, the hysteresis is turned off. In that case the block marks a read as urgent exactly when the fill is below the level-0 watermark.

Top module: `fph_prio_ctrl`

## Requirements
- R1: After reset `hi_prio` is 1, `trans_wm` is 0 and `trans_en` is 0.
- R2: Configuration inputs are captured only at a clock edge where `cfg_load` is 1. `trans_wm` and `trans_en` take their new values at the following edge. Configuration changes made without a load change neither these outputs nor the priority decisions.
- R3: For a plane that is not Y-tiled, `trans_wm` = level-0 watermark + 4 + transition amount + 1.
- R4: For a Y-tiled plane, the base is the larger of the level-0 watermark and ceil(2 × Y-tile minimum). `cfg_ytile_min` is unsigned with 16 integer bits (31:16) and 16 fraction bits (15:0), and any nonzero fraction after doubling rounds up. `trans_wm` = base + 4 + amount + 1.
- R5: When `cfg_early_fix` is 1, a plane that is not Y-tiled gets one extra block. A Y-tiled plane ignores the flag.
- R6: `trans_en` is 1 only when the pipe is active, idle priority control is enabled, and the watermark is no larger than `cfg_alloc`. A sum above 16'hFFFF gives `trans_wm` = 16'hFFFF and `trans_en` = 0.
- R7: With `trans_en` = 1, `hi_prio` goes to 0 one edge after the fill exceeds `trans_wm`. It goes to 1 one edge after the fill is below the level-0 watermark. For a fill between the two thresholds, inclusive, it holds its value.
- R8: With `trans_en` = 0, `hi_prio` is registered as (fill < level-0 watermark).
- R9: At a load edge, `hi_prio` is set to 1 whatever the fill is.
- R10: When the fill is below the level-0 watermark and above the transition watermark at the same time, `hi_prio` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Strobe that captures all cfg_* inputs |
| cfg_l0_wm | input | 16 | Level-0 watermark in blocks |
| cfg_y_tiled | input | 1 | Plane uses Y tiling |
| cfg_ytile_min | input | 32 | Y-tile minimum, 16.16 unsigned fixed point |
| cfg_trans_amt | input | 16 | Tunable transition amount in blocks |
| cfg_idle_en | input | 1 | Idle priority control enabled |
| cfg_pipe_on | input | 1 | Pipe active |
| cfg_early_fix | input | 1 | Early-silicon correction: one extra block for planes that are not Y-tiled |
| cfg_alloc | input | 16 | Buffer allocation in blocks |
| fill_lvl | input | 16 | Current buffer fill in blocks |
| hi_prio | output | 1 | 1 = issue reads at high priority |
| trans_wm | output | 16 | Computed transition watermark |
| trans_en | output | 1 | Transition hysteresis active |

## Verification
The watermark arithmetic is driven with configurations that separate its branches. A Y-tile minimum below the level-0 watermark and one above it show that the maximum is taken. Exact, tiny-fraction and half fractions of the Y-tile minimum expose rounding errors. The correction flag is set on both tiling modes, and allocations are placed one below and exactly at the watermark. The priority output is then walked through fills just below, at and above each threshold, which distinguishes true hysteresis from a single-threshold comparator. A reconfiguration made while reads are relaxed brings out the forced return to high priority and the rule that promotion wins when the thresholds conflict.

// File: rtl/fph_pkg.sv
// Shared widths and configuration record for the priority controller.
// Assumes block counts fit in BLK_W bits and the Y-tile minimum carries
// FRAC_W fraction bits below BLK_W integer bits.
package fph_pkg;
    localparam int BLK_W  = 16;
    localparam int FRAC_W = 16;
    localparam int FIX_W  = BLK_W + FRAC_W;

    typedef struct packed {
        logic [BLK_W-1:0] l0_wm;
        logic             y_tiled;
        logic [FIX_W-1:0] ytile_min;
        logic [BLK_W-1:0] trans_amt;
        logic             idle_en;
        logic             pipe_on;
        logic             early_fix;
        logic [BLK_W-1:0] alloc;
    } fph_cfg_t;
endpackage

// File: rtl/fph_cfg_reg.sv
// Configuration capture stage. Holds the configuration record, which
// changes only on a load strobe, and raises a one-cycle pending flag in
// the cycle after the strobe so the watermark stage can register its result.
// Assumes cfg_load is a single-cycle pulse or a level; each high edge reloads.
module fph_cfg_reg
    import fph_pkg::*;
#(
    parameter int DEF_AMT = 10
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_load,
    input  fph_cfg_t cfg_in,
    output fph_cfg_t cfg_q,
    output logic     upd_pend
);
    localparam logic [BLK_W-1:0] AMT_RST = BLK_W'(DEF_AMT);

    // Capture the configuration record on the load strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q           <= '0;
            cfg_q.trans_amt <= AMT_RST;
        end else if (cfg_load) begin
            cfg_q <= cfg_in;
        end
    end

    // Flag that the next edge should register a freshly computed watermark.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_pend <= 1'b0;
        else        upd_pend <= cfg_load;
    end
endmodule

// File: rtl/fph_wm_calc.sv
// Transition watermark arithmetic. Combinationally forms the threshold from
// the captured configuration and registers threshold and enable when the
// update flag is set. Arithmetic runs in BLK_W+3 bits so no sum wraps; a
// result past the block range saturates and disables the transition.
module fph_wm_calc
    import fph_pkg::*;
#(
    parameter int TRANS_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_pend,
    input  fph_cfg_t         cfg_q,
    output logic [BLK_W-1:0] trans_wm,
    output logic             trans_en
);
    localparam int SUM_W = BLK_W + 3;
    localparam int YW    = FIX_W + 2;
    localparam logic [YW-1:0] RND_ADD = YW'((64'd1 << FRAC_W) - 64'd1);

    logic [YW-1:0]    ydbl;
    logic [YW-1:0]    yrnd;
    logic [SUM_W-1:0] yceil;
    logic [SUM_W-1:0] l0_ext;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic             ovf;
    logic             fits;
    logic [BLK_W-1:0] wm_nxt;
    logic             en_nxt;

    // Double the Y-tile minimum and round any fraction up to a whole block.
    always_comb begin
        ydbl  = {1'b0, cfg_q.ytile_min, 1'b0};
        yrnd  = ydbl + RND_ADD;
        yceil = SUM_W'(yrnd[YW-1:FRAC_W]);
    end

    // Pick the base, add minimum, amount, the extra block and the correction.
    always_comb begin
        l0_ext = SUM_W'(cfg_q.l0_wm);
        base   = (cfg_q.y_tiled && (yceil > l0_ext)) ? yceil : l0_ext;
        sum    = base + SUM_W'(TRANS_MIN) + SUM_W'(cfg_q.trans_amt) + SUM_W'(1)
               + SUM_W'(cfg_q.early_fix && !cfg_q.y_tiled);
        ovf    = |sum[SUM_W-1:BLK_W];
        fits   = (sum <= SUM_W'(cfg_q.alloc));
        wm_nxt = ovf ? '1 : sum[BLK_W-1:0];
        en_nxt = cfg_q.pipe_on && cfg_q.idle_en && fits;
    end

    // Register the threshold and enable one cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trans_wm <= '0;
            trans_en <= 1'b0;
        end else if (upd_pend) begin
            trans_wm <= wm_nxt;
            trans_en <= en_nxt;
        end
    end

    // R6: an enabled threshold always lies inside the allocation and the pipe is live.
    assert_en_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend && trans_en) |-> (trans_wm <= cfg_q.alloc && cfg_q.pipe_on && cfg_q.idle_en))
        else $error("trans_en set with threshold outside allocation");

    // R3: an enabled threshold sits strictly above the level-0 watermark.
    assert_above_l0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend && trans_en) |-> (trans_wm > cfg_q.l0_wm))
        else $error("threshold not above level-0 watermark");
endmodule

// File: rtl/fph_prio_fsm.sv
// Priority hysteresis register. Promotes to high priority when the fill is
// under the level-0 watermark (this test is evaluated first, so it wins any
// conflict), demotes when the fill is over the transition watermark (or at
// or over level 0 when the transition is off), and otherwise holds.
// A load strobe forces high priority.
module fph_prio_fsm
    import fph_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [BLK_W-1:0] fill_lvl,
    input  logic [BLK_W-1:0] l0_wm,
    input  logic [BLK_W-1:0] trans_wm,
    input  logic             trans_en,
    output logic             hi_prio
);
    logic below_l0;
    logic above_hi;

    // Threshold comparisons for this cycle.
    always_comb begin
        below_l0 = (fill_lvl < l0_wm);
        above_hi = trans_en ? (fill_lvl > trans_wm) : 1'b1;
    end

    // Priority state update, one decision per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_prio <= 1'b1;
        else if (cfg_load) hi_prio <= 1'b1;
        else if (below_l0) hi_prio <= 1'b1;
        else if (above_hi) hi_prio <= 1'b0;
    end

    // R9: a load always leaves the controller at high priority.
    assert_load_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> hi_prio)
        else $error("load did not force high priority");

    // R10: a fill under level 0 promotes even if it also exceeds the upper threshold.
    assert_promote_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && fill_lvl < l0_wm) |=> hi_prio)
        else $error("starved buffer not promoted");

    // R7: with hysteresis on, a fill past the transition threshold demotes.
    assert_demote_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && trans_en && fill_lvl >= l0_wm && fill_lvl > trans_wm) |=> !hi_prio)
        else $error("fill above transition threshold not demoted");

    // R7: between the thresholds the priority holds its value.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && trans_en && fill_lvl >= l0_wm && fill_lvl <= trans_wm) |=> $stable(hi_prio))
        else $error("priority changed inside the hysteresis band");

    // R8: with hysteresis off, a fill at or above level 0 is low priority.
    assert_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !trans_en && fill_lvl >= l0_wm) |=> !hi_prio)
        else $error("plain mode did not demote");
endmodule

// File: rtl/fph_prio_ctrl.sv
// Top of the display read-buffer priority controller. Wires the
// configuration capture, the watermark arithmetic and the priority
// hysteresis together. Assumes fill_lvl is valid every cycle.
module fph_prio_ctrl
    import fph_pkg::*;
#(
    parameter int TRANS_MIN = 4,
    parameter int DEF_AMT   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [15:0]      cfg_l0_wm,
    input  logic             cfg_y_tiled,
    input  logic [31:0]      cfg_ytile_min,
    input  logic [15:0]      cfg_trans_amt,
    input  logic             cfg_idle_en,
    input  logic             cfg_pipe_on,
    input  logic             cfg_early_fix,
    input  logic [15:0]      cfg_alloc,
    input  logic [15:0]      fill_lvl,
    output logic             hi_prio,
    output logic [15:0]      trans_wm,
    output logic             trans_en
);
    fph_cfg_t cfg_in;
    fph_cfg_t cfg_q;
    logic     upd_pend;

    // Pack the configuration pins into the shared record.
    always_comb begin
        cfg_in.l0_wm     = cfg_l0_wm;
        cfg_in.y_tiled   = cfg_y_tiled;
        cfg_in.ytile_min = cfg_ytile_min;
        cfg_in.trans_amt = cfg_trans_amt;
        cfg_in.idle_en   = cfg_idle_en;
        cfg_in.pipe_on   = cfg_pipe_on;
        cfg_in.early_fix = cfg_early_fix;
        cfg_in.alloc     = cfg_alloc;
    end

    fph_cfg_reg #(.DEF_AMT(DEF_AMT)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q),
        .upd_pend (upd_pend)
    );

    fph_wm_calc #(.TRANS_MIN(TRANS_MIN)) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_pend (upd_pend),
        .cfg_q    (cfg_q),
        .trans_wm (trans_wm),
        .trans_en (trans_en)
    );

    fph_prio_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .fill_lvl (fill_lvl),
        .l0_wm    (cfg_q.l0_wm),
        .trans_wm (trans_wm),
        .trans_en (trans_en),
        .hi_prio  (hi_prio)
    );

    // R2: outputs move only in the cycle following a load.
    assert_wm_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend) |=> ($stable(trans_wm) && $stable(trans_en)))
        else $error("watermark changed without a load");
endmodule

// File: tb/test_fph_prio_ctrl.sv
`timescale 1ns/1ps
module test_fph_prio_ctrl;
    typedef struct packed {
        logic        yt;
        logic [31:0] ytm;
        logic [15:0] l0;
        logic [15:0] amt;
        logic        early;
        logic        idle;
        logic        pipe;
        logic [15:0] alloc;
        logic [15:0] exp_wm;
        logic        exp_en;
    } vec_t;

    // Watermark vectors: yt, ytm, l0, amt, early, idle, pipe, alloc, wm, en
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,         16'd20,     16'd10,  1'b0, 1'b1, 1'b1, 16'd100,    16'd35,     1'b1}, // R3
        '{1'b0, 32'h0,         16'd20,     16'd10,  1'b1, 1'b1, 1'b1, 16'd100,    16'd36,     1'b1}, // R5
        '{1'b1, 32'h0008_0000, 16'd20,     16'd10,  1'b1, 1'b1, 1'b1, 16'd100,    16'd35,     1'b1}, // R5 R4
        '{1'b1, 32'h0010_8000, 16'd20,     16'd10,  1'b0, 1'b1, 1'b1, 16'd100,    16'd48,     1'b1}, // R4
        '{1'b1, 32'h0010_0001, 16'd20,     16'd10,  1'b0, 1'b1, 1'b1, 16'd100,    16'd48,     1'b1}, // R4
        '{1'b1, 32'h0010_0000, 16'd20,     16'd10,  1'b0, 1'b1, 1'b1, 16'd100,    16'd47,     1'b1}, // R4
        '{1'b0, 32'h0,         16'd20,     16'd0,   1'b0, 1'b1, 1'b1, 16'd100,    16'd25,     1'b1}, // R3
        '{1'b0, 32'h0,         16'd20,     16'd10,  1'b0, 1'b1, 1'b1, 16'd34,     16'd35,     1'b0}, // R6
        '{1'b0, 32'h0,         16'd20,     16'd10,  1'b0, 1'b1, 1'b1, 16'd35,     16'd35,     1'b1}, // R6
        '{1'b0, 32'h0,         16'd20,     16'd10,  1'b0, 1'b0, 1'b1, 16'd100,    16'd35,     1'b0}, // R6
        '{1'b0, 32'h0,         16'd20,     16'd10,  1'b0, 1'b1, 1'b0, 16'd100,    16'd35,     1'b0}, // R6
        '{1'b0, 32'h0,         16'hFFF0,   16'd10,  1'b0, 1'b1, 1'b1, 16'hFFFF,   16'hFFFF,   1'b1}, // R6
        '{1'b0, 32'h0,         16'hFFF0,   16'd100, 1'b0, 1'b1, 1'b1, 16'hFFFF,   16'hFFFF,   1'b0}, // R6
        '{1'b1, 32'hFFFF_FFFF, 16'd0,      16'd10,  1'b0, 1'b1, 1'b1, 16'hFFFF,   16'hFFFF,   1'b0}  // R4 R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_l0_wm = '0;
    logic        cfg_y_tiled = 1'b0;
    logic [31:0] cfg_ytile_min = '0;
    logic [15:0] cfg_trans_amt = '0;
    logic        cfg_idle_en = 1'b0;
    logic        cfg_pipe_on = 1'b0;
    logic        cfg_early_fix = 1'b0;
    logic [15:0] cfg_alloc = '0;
    logic [15:0] fill_lvl = '0;
    logic        hi_prio;
    logic [15:0] trans_wm;
    logic        trans_en;

    int n_chk = 0;
    int n_bad = 0;
    logic hi_at_load;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fph_prio_ctrl i_fph_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_l0_wm(cfg_l0_wm),
        .cfg_y_tiled(cfg_y_tiled), .cfg_ytile_min(cfg_ytile_min),
        .cfg_trans_amt(cfg_trans_amt), .cfg_idle_en(cfg_idle_en),
        .cfg_pipe_on(cfg_pipe_on), .cfg_early_fix(cfg_early_fix),
        .cfg_alloc(cfg_alloc), .fill_lvl(fill_lvl), .hi_prio(hi_prio),
        .trans_wm(trans_wm), .trans_en(trans_en)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drives the vector, loads it, returns at the
    // falling edge after the watermark has been registered.
    task automatic apply_cfg(input vec_t v);
        cfg_y_tiled   = v.yt;
        cfg_ytile_min = v.ytm;
        cfg_l0_wm     = v.l0;
        cfg_trans_amt = v.amt;
        cfg_early_fix = v.early;
        cfg_idle_en   = v.idle;
        cfg_pipe_on   = v.pipe;
        cfg_alloc     = v.alloc;
        cfg_load      = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_load   = 1'b0;
        hi_at_load = hi_prio;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a falling edge: drives a fill and checks priority one edge later.
    task automatic step(input logic [15:0] f, input logic exp, input string tag);
        fill_lvl = f;
        @(posedge clk);
        @(negedge clk);
        check(tag, {15'd0, hi_prio}, {15'd0, exp});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 hi_prio", {15'd0, hi_prio}, 16'd1);
        check("R1 trans_wm", trans_wm, 16'd0);
        check("R1 trans_en", {15'd0, trans_en}, 16'd0);

        // R3 R4 R5 R6: watermark table
        fill_lvl = 16'd0;
        for (int i = 0; i < NV; i++) begin
            apply_cfg(VECS[i]);
            check($sformatf("R3-6 wm vec%0d", i), trans_wm, VECS[i].exp_wm);
            check($sformatf("R3-6 en vec%0d", i), {15'd0, trans_en}, {15'd0, VECS[i].exp_en});
        end

        // R7: hysteresis with l0=20, wm=35
        apply_cfg(VECS[0]);
        step(16'd30, 1'b1, "R7 below upper stays high");
        step(16'd35, 1'b1, "R7 at upper stays high");
        step(16'd36, 1'b0, "R7 above upper demotes");
        step(16'd25, 1'b0, "R7 band holds low");
        step(16'd20, 1'b0, "R7 at l0 holds low");
        step(16'd19, 1'b1, "R7 below l0 promotes");
        step(16'd30, 1'b1, "R7 band holds high");
        step(16'd36, 1'b0, "R7 demote again");

        // R9 R10: reload while low, with fill above old upper and below new l0
        fill_lvl = 16'd50;
        apply_cfg('{1'b0, 32'h0, 16'd100, 16'd10, 1'b0, 1'b1, 1'b1, 16'd200, 16'd115, 1'b1});
        check("R9 load forces high", {15'd0, hi_at_load}, 16'd1);
        check("R10 promotion wins conflict", {15'd0, hi_prio}, 16'd1);
        check("R10 new wm", trans_wm, 16'd115);

        // R8: hysteresis off (idle disabled), l0=20
        apply_cfg(VECS[9]);
        step(16'd19, 1'b1, "R8 below l0 high");
        step(16'd20, 1'b0, "R8 at l0 low");
        step(16'd25, 1'b0, "R8 above l0 low");
        step(16'd10, 1'b1, "R8 below l0 again high");
        step(16'd30, 1'b0, "R8 no band in plain mode");

        // R2: inputs changed without a load have no effect
        cfg_l0_wm     = 16'd500;
        cfg_trans_amt = 16'd77;
        cfg_idle_en   = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 wm unchanged", trans_wm, 16'd35);
        check("R2 en unchanged", {15'd0, trans_en}, 16'd0);
        step(16'd30, 1'b0, "R2 old l0 still used");

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 hi_prio after reset", {15'd0, hi_prio}, 16'd1);
        check("R1 wm after reset", trans_wm, 16'd0);
        check("R1 en after reset", {15'd0, trans_en}, 16'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule